// File: doc/BRIEF.md
# Per-Channel Fine Gain and Offset Trim

This block sits after the sample converters of a three-channel video path. Each channel carries a 10-bit sample. The block multiplies each sample by a fine gain of 1 + N/256, where N is an 8-bit code. It rounds the product to an integer and adds a signed 10-bit offset. It then limits the result to the 10-bit code range. Every channel has its own gain code and offset code.

Samples arrive as a valid/data stream, with all three channels packed in one word. The trimmed word leaves exactly two clocks later, with its own valid flag. The gain and offset inputs are plain levels that the block reads for each accepted sample. A setting can be changed at any time: each sample is processed with the setting that was present in the cycle it was accepted, and no sample mixes old and new settings. A parameter selects round-half-up (the default) or truncation of the scaled product.

Top module: `pix_fine_trim`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: A channel with gain code 0 and offset code 0 outputs its input sample unchanged.
- R3: In the default rounding mode, each channel outputs floor((x·(256+N) + 128) / 256) + offset, computed without loss at 19 bits. Here x is the 10-bit unsigned sample, N is the 8-bit unsigned gain code, and the offset is the 10-bit two's-complement code (−512..+511).
- R4: Channel c uses sample bits [c·10 +: 10], gain bits [c·8 +: 8] and offset bits [c·10 +: 10], and writes output bits [c·10 +: 10]. Channel 0 occupies the least significant bits, and channels do not affect each other.
- R5: A result above 1023 is output as 1023, with no wraparound.
- R6: A result below 0 is output as 0, with no wraparound.
- R7: `out_valid` equals `in_valid` from two clocks earlier. The output of an accepted sample appears in the same cycle as its `out_valid`.
- R8: Sample, gain and offset are all captured in the cycle the sample is accepted. Changes made in later cycles do not affect that sample's result.
- R9: Input data and settings presented while `in_valid` is 0 are ignored. While `out_valid` is 0, `out_data` holds the last valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample word present this cycle |
| in_data | input | NCH*DW (30) | Packed input samples, channel 0 in LSBs |
| cfg_gain | input | NCH*GW (24) | Packed unsigned fine gain codes |
| cfg_offset | input | NCH*OW (30) | Packed two's-complement offset codes |
| out_valid | output | 1 | Trimmed word present this cycle |
| out_data | output | NCH*DW (30) | Packed trimmed samples |

## Verification
The bench builds the block at its default parameters: three channels, 10-bit samples, an 8-bit gain and a 10-bit offset, with round-half-up. At these sizes a sweep of 32768 cycles visits every input code, every gain code and every offset code, and it changes the settings on every cycle and leaves gaps in the stream. The sweep therefore reaches both saturation limits, the exact half-count rounding points and the cases where the settings change between adjacent samples. Each result is compared with a value the bench computes arithmetically.

// File: rtl/trim_pkg.sv
package trim_pkg;
   // Selects how the scaled product is reduced to an integer count.
   typedef enum logic {
      RND_TRUNC   = 1'b0,
      RND_HALF_UP = 1'b1
   } trim_round_e;
endpackage

// File: rtl/trim_gain.sv
module trim_gain
   import trim_pkg::*;
#(
   parameter int          DW    = 10,
   parameter int          GW    = 8,
   parameter int          OW    = 10,
   parameter trim_round_e RMODE = RND_HALF_UP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW-1:0] x,
   input  logic [GW-1:0] g,
   input  logic [OW-1:0] o,
   output logic [DW:0]   rnd_q,
   output logic [OW-1:0] ofs_q
);
   localparam int PW = DW + GW + 1;   // full product width, no loss

   logic [PW-1:0] prod;
   logic [PW-1:0] rsum;
   logic [DW:0]   rnd_d;

   // Gain factor is {1,g}/2^GW, i.e. 1 + g/2^GW.
   assign prod = PW'(x) * PW'({1'b1, g});

   generate
      if (RMODE == RND_HALF_UP) begin : g_half_up
         assign rsum = prod + PW'(1 << (GW - 1));
      end else begin : g_trunc
         assign rsum = prod;
      end
   endgenerate

   assign rnd_d = (DW+1)'(rsum >> GW);

   // Scaled sample and offset are captured together, so the offset
   // applied in the next stage belongs to the same sample.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnd_q <= '0;
         ofs_q <= '0;
      end else if (ld) begin
         rnd_q <= rnd_d;
         ofs_q <= o;
      end
   end
endmodule

// File: rtl/trim_sat.sv
module trim_sat #(
   parameter int DW = 10,
   parameter int OW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [DW:0]   rnd,
   input  logic [OW-1:0] ofs,
   output logic [DW-1:0] y
);
   localparam int SW = ((DW + 2 > OW) ? DW + 2 : OW) + 1;
   localparam logic signed [SW-1:0] MAXC = SW'((1 << DW) - 1);

   logic signed [SW-1:0] s_r;
   logic signed [SW-1:0] s_o;
   logic signed [SW-1:0] sum;
   logic [DW-1:0]        y_d;

   assign s_r = $signed({{(SW-DW-1){1'b0}}, rnd});
   assign s_o = $signed({{(SW-OW){ofs[OW-1]}}, ofs});
   assign sum = s_r + s_o;

   always_comb begin
      if (sum < 0)         y_d = '0;
      else if (sum > MAXC) y_d = '1;
      else                 y_d = sum[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  y <= '0;
      else if (ld) y <= y_d;
   end

   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && (s_r + s_o > MAXC)) |=> (y == {DW{1'b1}}));   // R5
   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ld && (s_r + s_o < 0)) |=> (y == '0));              // R6
endmodule

// File: rtl/pix_fine_trim.sv
module pix_fine_trim
   import trim_pkg::*;
#(
   parameter int          NCH   = 3,
   parameter int          DW    = 10,
   parameter int          GW    = 8,
   parameter int          OW    = 10,
   parameter trim_round_e RMODE = RND_HALF_UP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [NCH*DW-1:0] in_data,
   input  logic [NCH*GW-1:0] cfg_gain,
   input  logic [NCH*OW-1:0] cfg_offset,
   output logic              out_valid,
   output logic [NCH*DW-1:0] out_data
);
   localparam int PW = DW + GW + 1;

   generate
      if (NCH < 1) begin : g_bad_nch
         $error("pix_fine_trim: NCH must be at least 1");
      end
      if (GW < 1) begin : g_bad_gw
         $error("pix_fine_trim: GW must be at least 1");
      end
      if (OW < 2) begin : g_bad_ow
         $error("pix_fine_trim: OW must be at least 2");
      end
      if (PW < 18) begin : g_bad_pw
         $error("pix_fine_trim: product narrower than 18 bits");
      end
   endgenerate

   logic v1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1        <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         v1        <= in_valid;
         out_valid <= v1;
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic [DW:0]   rnd;
         logic [OW-1:0] ofs;

         trim_gain #(.DW(DW), .GW(GW), .OW(OW), .RMODE(RMODE)) u_gain (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (in_valid),
            .x     (in_data[c*DW +: DW]),
            .g     (cfg_gain[c*GW +: GW]),
            .o     (cfg_offset[c*OW +: OW]),
            .rnd_q (rnd),
            .ofs_q (ofs)
         );

         trim_sat #(.DW(DW), .OW(OW)) u_sat (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (v1),
            .rnd   (rnd),
            .ofs   (ofs),
            .y     (out_data[c*DW +: DW])
         );

         AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && cfg_gain[c*GW +: GW] == '0 && cfg_offset[c*OW +: OW] == '0)
            |-> ##2 (out_data[c*DW +: DW] == $past(in_data[c*DW +: DW], 2)));   // R2
      end
   endgenerate

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);                                 // R7
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);                               // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));                           // R9
   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_data == '0));                  // R1
endmodule

// File: tb/sim_pix_fine_trim.sv
module sim_pix_fine_trim;
   localparam int NCH = 3;
   localparam int DW  = 10;
   localparam int GW  = 8;
   localparam int OW  = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [NCH*DW-1:0] in_data = '0;
   logic [NCH*GW-1:0] cfg_gain = '0;
   logic [NCH*OW-1:0] cfg_offset = '0;
   logic              out_valid;
   logic [NCH*DW-1:0] out_data;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   // Expected-value pipeline: slot 1 was driven one cycle ago, slot 2 two cycles ago.
   logic              ev1 = 1'b0, ev2 = 1'b0;
   logic [NCH*DW-1:0] ed1 = '0, ed2 = '0;
   string             tg1 = "R3", tg2 = "R3";
   logic [NCH*DW-1:0] last_out = '0;
   logic [NCH*GW-1:0] prev_g = '0;
   logic [NCH*OW-1:0] prev_o = '0;

   always #4 clk = ~clk;   // 125 MHz

   pix_fine_trim #(.NCH(NCH), .DW(DW), .GW(GW), .OW(OW)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .cfg_gain   (cfg_gain),
      .cfg_offset (cfg_offset),
      .out_valid  (out_valid),
      .out_data   (out_data)
   );

   // Unclamped result: round-half-up of x*(1+g/256), plus the signed offset.
   function automatic int raw_val(int x, int g, int o);
      return ((x * (256 + g) + 128) >>> 8) + o;
   endfunction

   function automatic int clip(int v);
      if (v < 0)    return 0;
      if (v > 1023) return 1023;
      return v;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle: check the outputs for the sample driven two cycles ago,
   // then drive a new sample. xs/gs/os are per-channel values.
   task automatic cycle(logic v, int xs[NCH], int gs[NCH], int os[NCH], string force_tag);
      logic [NCH*DW-1:0] e;
      string t;
      bit hi, lo, unity, chg;
      @(negedge clk);
      check("R7 out_valid", 64'(out_valid), 64'(ev2));
      if (ev2) begin
         check(tg2, 64'(out_data), 64'(ed2));
         last_out = ed2;
      end else begin
         check("R9 hold while idle", 64'(out_data), 64'(last_out));
      end
      ev2 = ev1; ed2 = ed1; tg2 = tg1;
      hi = 0; lo = 0; unity = 1;
      for (int c = 0; c < NCH; c++) begin
         int r;
         r = raw_val(xs[c], gs[c], os[c]);
         if (r > 1023) hi = 1;
         if (r < 0) lo = 1;
         if (gs[c] != 0 || os[c] != 0) unity = 0;
         e[c*DW +: DW] = DW'(clip(r));
         in_data[c*DW +: DW]    = DW'(xs[c]);
         cfg_gain[c*GW +: GW]   = GW'(gs[c]);
         cfg_offset[c*OW +: OW] = OW'(os[c]);
      end
      chg = (cfg_gain != prev_g) || (cfg_offset != prev_o);
      prev_g = cfg_gain; prev_o = cfg_offset;
      if (force_tag != "") t = force_tag;
      else if (hi)         t = "R5 saturate high";
      else if (lo)         t = "R6 saturate low";
      else if (unity)      t = "R2 unity pass";
      else if (chg)        t = "R8 per-sample settings";
      else                 t = "R3 gain and offset";
      in_valid = v;
      ev1 = v; tg1 = t;
      if (v) ed1 = e;
   endtask

   task automatic same3(logic v, int x, int g, int o, string tag);
      int xs[NCH], gs[NCH], os[NCH];
      for (int c = 0; c < NCH; c++) begin
         xs[c] = x; gs[c] = g; os[c] = o;
      end
      cycle(v, xs, gs, os, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      int xs[NCH], gs[NCH], os[NCH];
      repeat (3) @(negedge clk);
      check("R1 reset valid", 64'(out_valid), 64'(0));
      check("R1 reset data", 64'(out_data), 64'(0));
      // Garbage on the inputs during reset must not leak out.
      in_valid = 1'b1; in_data = '1; cfg_gain = '1;
      @(negedge clk);
      check("R1 reset data with busy inputs", 64'(out_data), 64'(0));
      in_valid = 1'b0; in_data = '0; cfg_gain = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first cycle valid", 64'(out_valid), 64'(0));
      check("R1 first cycle data", 64'(out_data), 64'(0));

      // R2 pass-through at unity settings
      same3(1, 0, 0, 0, "R2 unity zero");
      same3(1, 1, 0, 0, "R2 unity one");
      same3(1, 512, 0, 0, "R2 unity mid");
      same3(1, 1023, 0, 0, "R2 unity top");

      // R4 channels with distinct settings
      xs = '{600, 600, 600}; gs = '{0, 128, 255}; os = '{0, -100, -300};
      cycle(1, xs, gs, os, "R4 independent channels");
      xs = '{5, 700, 1000}; gs = '{200, 0, 64}; os = '{511, 3, -512};
      cycle(1, xs, gs, os, "R4 independent channels");

      // R3 rounding edges: 1*1.5 -> 2, 1*(383/256) -> 1
      same3(1, 1, 128, 0, "R3 half rounds up");
      same3(1, 1, 127, 0, "R3 below half rounds down");
      // R5 / R6 extremes
      same3(1, 1023, 255, 511, "R5 max clamp");
      same3(1, 0, 0, -512, "R6 min clamp");
      same3(1, 1023, 0, -1, "R3 just under top");

      // R9 idle cycles with changing garbage
      same3(0, 77, 33, 100, "R9 ignored");
      same3(0, 900, 250, -400, "R9 ignored");

      // Sweep: settings change every cycle, gaps in the stream.
      for (int i = 0; i < 32768; i++) begin
         logic v;
         v = (i % 13) != 7;
         xs[0] = i & 1023;            gs[0] = (i >> 7) & 255;  os[0] = ((i >> 3) & 1023) - 512;
         xs[1] = 1023 - (i & 1023);   gs[1] = i & 255;         os[1] = ((i >> 5) & 1023) - 512;
         xs[2] = (i * 7) & 1023;      gs[2] = (i * 13) & 255;  os[2] = ((i * 29) & 1023) - 512;
         cycle(v, xs, gs, os, "");
      end

      // Drain the pipeline.
      for (int k = 0; k < 3; k++) same3(0, 0, 0, 0, "R9 drain");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule